// File: doc/BRIEF.md
# Three-Channel Memory-to-Memory DMA Engine

This block copies blocks of 32-bit words from one address to another over a single-master memory port. It has three channels, and each channel keeps its own source pointer, destination pointer, remaining word count and control word. Software writes these through a small word-addressed register port. A channel starts when software sets its go bit, or when the hardware request line it selects goes high while the channel is armed.

Only one channel uses the bus at a time. An arbiter picks the ready channel with the highest programmed priority. It decides again only after each burst. A burst is 1, 4 or 8 words. When fewer words remain than the burst size, each remaining word is sent on its own, and the arbiter decides again before each one. Each word is one read from the source followed by one write of the same data to the destination.

A finished channel sets a done flag. A channel whose bus access is refused sets an error flag. Both flags stay set until software clears them, and a per-channel mask decides which flags drive the interrupt line.

Top module: `dma_engine`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and `mem_req_o` is low. Register words are addressed as follows: channel c uses 4c+0 for the source address, 4c+1 for the destination address, 4c+2 for the remaining count and 4c+3 for control. Word 12 holds the status and word 13 holds the interrupt mask.
- R2: Writing control with bit 0 (enable) and bit 1 (go) both set starts the channel. When control is read, bit 1 shows that the channel is busy.
- R3: Control bit 9 arms the hardware trigger, and bits [8:6] pick request line 0 to 6. A high level on the picked line starts an armed, enabled, idle channel. Select value 7 picks no line, and a high level on any line other than the picked one has no effect.
- R4: Each word is a read at the source followed by a write of the read data to the destination. While a request is not granted, `mem_req_o`, `mem_addr_o` and `mem_we_o` stay unchanged. A granted read with no error is followed by the write request in the next cycle.
- R5: Control bit 2 makes the source address increment and bit 3 makes the destination address increment. An incrementing address grows by 4 after each completed word. A fixed address does not change.
- R6: Control bits [5:4] set the burst size: 0 gives 1 word, 1 gives 4 words, 2 gives 8 words and 3 gives 1 word. While the remaining count is at least the burst size, the channel keeps the bus for a whole burst. Once fewer words remain than the burst size, each word is a single transfer with arbitration before it.
- R7: Control bits [12:10] set the priority, and a larger value wins. Among ready channels with equal priority, the lowest index wins. Arbitration happens only between bursts or single transfers.
- R8: When the remaining count reaches 0, the channel clears its enable bit and sets status bit c (done). A channel started with a count of 0 finishes without any bus access.
- R9: If `mem_err_i` is high with a grant, the channel stops and clears its enable bit, and status bit 4+c (error) is set. The count and the addresses keep the values of the word that failed, and no request is made in the next cycle.
- R10: Status flags stay set until software writes 1 to that bit of word 12. Writing 0 leaves a flag unchanged.
- R11: `irq_o` is the OR over all channels of (done or error) ANDed with bit c of the mask word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| hw_req_i | input | 7 | Hardware request lines |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write (1) or read (0) |
| mem_addr_o | output | 32 | Bus byte address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_gnt_i | input | 1 | Bus grant, completes the access |
| mem_rdata_i | input | 32 | Read data, valid with the grant |
| mem_err_i | input | 1 | Bus error, valid with the grant |
| irq_o | output | 1 | Masked interrupt |

## Verification
Single copies run in all four addressing combinations, with burst sizes larger and smaller than the count, under a grant that stalls every other cycle. These runs separate the increment logic from the fixed-address logic and show that the bus stays stable while stalled. Pairs of channels fired on one request line separate higher-priority-first order from index order on a tie. A high-priority channel that becomes ready partway through another channel's transfer shows that it cuts in between single transfers but waits for a whole burst to finish. A wrong line, the no-line select, a zero count and a faulting address check that the block starts only when it should and stops with the right state left in its registers.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned REGS_PER_CH = 4;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_GO   = 1;
  localparam int CB_SINC = 2;
  localparam int CB_DINC = 3;
  localparam int CB_BL   = 4;
  localparam int CB_SEL  = 6;
  localparam int CB_HW   = 9;
  localparam int CB_PRI  = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_st_e;

  function automatic logic [3:0] burst_words(input logic [1:0] code);
    case (code)
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int unsigned NCH = 3,
  parameter int unsigned PW  = 3,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]         ready_i,
  input  logic [NCH-1:0][PW-1:0] prio_i,
  output logic                   valid_o,
  output logic [IW-1:0]          win_o
);
  logic [PW-1:0] best;

  // strict greater-than keeps the lowest index on a tie
  always_comb begin
    valid_o = 1'b0;
    win_o   = '0;
    best    = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ready_i[i] && (!valid_o || prio_i[i] > best)) begin
        valid_o = 1'b1;
        win_o   = IW'(i);
        best    = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 16,
  parameter int unsigned NREQ = 7,
  parameter int unsigned PW   = 3,
  localparam int unsigned SW  = $clog2(NREQ + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [1:0]      wsel_i,
  input  logic [31:0]     wdata_i,
  input  logic [NREQ-1:0] hw_req_i,
  input  logic            step_i,
  input  logic            err_i,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   dst_o,
  output logic [CW-1:0]   cnt_o,
  output logic [31:0]     ctl_o,
  output logic [1:0]      burst_o,
  output logic [PW-1:0]   prio_o,
  output logic            active_o,
  output logic            done_o,
  output logic            fault_o
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, act_q, sinc_q, dinc_q, hw_q;
  logic [1:0]    bl_q;
  logic [SW-1:0] sel_q;
  logic [PW-1:0] pri_q;
  logic [2**SW-1:0] req_pad;
  logic          hw_fire;

  // top select code(s) beyond NREQ map to constant-low lines
  assign req_pad = {{(2**SW - NREQ){1'b0}}, hw_req_i};
  assign hw_fire = en_q & hw_q & req_pad[sel_q] & ~act_q;
  assign done_o  = act_q & (cnt_q == '0);
  assign fault_o = act_q & err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0;
      en_q <= 1'b0; act_q <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0;
      hw_q <= 1'b0; bl_q <= '0; sel_q <= '0; pri_q <= '0;
    end else begin
      if (wr_i) begin
        unique case (wsel_i)
          2'd0: src_q <= wdata_i[AW-1:0];
          2'd1: dst_q <= wdata_i[AW-1:0];
          2'd2: cnt_q <= wdata_i[CW-1:0];
          2'd3: begin
            en_q   <= wdata_i[CB_EN];
            sinc_q <= wdata_i[CB_SINC];
            dinc_q <= wdata_i[CB_DINC];
            bl_q   <= wdata_i[CB_BL +: 2];
            sel_q  <= wdata_i[CB_SEL +: SW];
            hw_q   <= wdata_i[CB_HW];
            pri_q  <= wdata_i[CB_PRI +: PW];
            if (wdata_i[CB_EN] && wdata_i[CB_GO]) act_q <= 1'b1;
            else if (!wdata_i[CB_EN])             act_q <= 1'b0;
          end
        endcase
      end
      if (hw_fire) act_q <= 1'b1;
      if (step_i) begin
        if (sinc_q) src_q <= src_q + AW'(4);
        if (dinc_q) dst_q <= dst_q + AW'(4);
        cnt_q <= cnt_q - CW'(1);
      end
      if (done_o || fault_o) begin
        act_q <= 1'b0;
        en_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl_o = '0;
    ctl_o[CB_EN]         = en_q;
    ctl_o[CB_GO]         = act_q;
    ctl_o[CB_SINC]       = sinc_q;
    ctl_o[CB_DINC]       = dinc_q;
    ctl_o[CB_BL +: 2]    = bl_q;
    ctl_o[CB_SEL +: SW]  = sel_q;
    ctl_o[CB_HW]         = hw_q;
    ctl_o[CB_PRI +: PW]  = pri_q;
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign cnt_o    = cnt_q;
  assign burst_o  = bl_q;
  assign prio_o   = pri_q;
  assign active_o = act_q;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned NCH  = 3,
  parameter int unsigned NREQ = 7,
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 16,
  parameter int unsigned PW   = 3,
  localparam int unsigned RAW  = $clog2(REGS_PER_CH * NCH + 2),
  localparam int unsigned IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned ELSB = (NCH > 4) ? NCH : 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [RAW-1:0]  cfg_addr_i,
  input  logic [31:0]     cfg_wdata_i,
  output logic [31:0]     cfg_rdata_o,
  input  logic [NREQ-1:0] hw_req_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_gnt_i,
  input  logic [31:0]     mem_rdata_i,
  input  logic            mem_err_i,
  output logic            irq_o
);
  localparam logic [RAW-1:0] A_STAT = RAW'(REGS_PER_CH * NCH);
  localparam logic [RAW-1:0] A_MASK = RAW'(REGS_PER_CH * NCH + 1);

  logic [NCH-1:0][AW-1:0] src, dst;
  logic [NCH-1:0][CW-1:0] cnt;
  logic [NCH-1:0][31:0]   ctl;
  logic [NCH-1:0][1:0]    bl;
  logic [NCH-1:0][PW-1:0] pri;
  logic [NCH-1:0] active, done_p, fault_p, step, ferr, ready;
  logic [NCH-1:0] done_q, err_q, mask_q, dclr, eclr;

  dma_st_e       state_q;
  logic [IW-1:0] cur_q, win;
  logic [3:0]    beats_q, blen, first;
  logic [31:0]   data_q, stat_rd;
  logic          win_vld, xfer_ok, xfer_bad;
  logic [RAW-3:0] ch_sel;

  assign ch_sel = cfg_addr_i[RAW-1:2];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_ch;
    assign wr_ch    = cfg_we_i && (cfg_addr_i < A_STAT) && (ch_sel == (RAW-2)'(g));
    assign ready[g] = active[g] && (cnt[g] != '0);
    dma_chan #(.AW(AW), .CW(CW), .NREQ(NREQ), .PW(PW)) u_chan (
      .clk_i, .rst_ni,
      .wr_i(wr_ch), .wsel_i(cfg_addr_i[1:0]), .wdata_i(cfg_wdata_i),
      .hw_req_i, .step_i(step[g]), .err_i(ferr[g]),
      .src_o(src[g]), .dst_o(dst[g]), .cnt_o(cnt[g]), .ctl_o(ctl[g]),
      .burst_o(bl[g]), .prio_o(pri[g]), .active_o(active[g]),
      .done_o(done_p[g]), .fault_o(fault_p[g])
    );
  end

  dma_arb #(.NCH(NCH), .PW(PW)) u_arb (
    .ready_i(ready), .prio_i(pri), .valid_o(win_vld), .win_o(win)
  );

  // a burst only when enough words remain, else one single word
  assign blen  = burst_words(bl[win]);
  assign first = (CW'(blen) <= cnt[win]) ? blen : 4'd1;

  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_WR) ? dst[cur_q] : src[cur_q];
  assign mem_wdata_o = data_q;
  assign xfer_ok     = mem_req_o && mem_gnt_i && !mem_err_i;
  assign xfer_bad    = mem_req_o && mem_gnt_i && mem_err_i;
  assign step        = (state_q == ST_WR && xfer_ok) ? (NCH'(1) << cur_q) : '0;
  assign ferr        = xfer_bad ? (NCH'(1) << cur_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      beats_q <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (win_vld) begin
          cur_q   <= win;
          beats_q <= first;
          state_q <= ST_RD;
        end
        ST_RD: begin
          if (xfer_bad) state_q <= ST_IDLE;
          else if (xfer_ok) begin
            data_q  <= mem_rdata_i;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (xfer_bad) state_q <= ST_IDLE;
          else if (xfer_ok) begin
            beats_q <= beats_q - 4'd1;
            state_q <= (beats_q == 4'd1) ? ST_IDLE : ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dclr = (cfg_we_i && cfg_addr_i == A_STAT) ? cfg_wdata_i[NCH-1:0] : '0;
  assign eclr = (cfg_we_i && cfg_addr_i == A_STAT) ? cfg_wdata_i[ELSB +: NCH] : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      err_q  <= '0;
      mask_q <= '0;
    end else begin
      done_q <= (done_q & ~dclr) | done_p;
      err_q  <= (err_q & ~eclr) | fault_p;
      if (cfg_we_i && cfg_addr_i == A_MASK) mask_q <= cfg_wdata_i[NCH-1:0];
    end
  end

  assign irq_o = |((done_q | err_q) & mask_q);

  always_comb begin
    stat_rd = '0;
    stat_rd[NCH-1:0]     = done_q;
    stat_rd[ELSB +: NCH] = err_q;
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i < A_STAT) begin
      unique case (cfg_addr_i[1:0])
        2'd0: cfg_rdata_o = 32'(src[ch_sel]);
        2'd1: cfg_rdata_o = 32'(dst[ch_sel]);
        2'd2: cfg_rdata_o = 32'(cnt[ch_sel]);
        2'd3: cfg_rdata_o = ctl[ch_sel];
      endcase
    end else if (cfg_addr_i == A_STAT) begin
      cfg_rdata_o = stat_rd;
    end else if (cfg_addr_i == A_MASK) begin
      cfg_rdata_o = 32'(mask_q);
    end
  end
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int unsigned NCH = 3,
  parameter int unsigned AW  = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           mem_gnt_i,
  input logic           mem_err_i,
  input logic           irq_o,
  input logic [NCH-1:0] done_flags_i,
  input logic [NCH-1:0] err_flags_i
);
  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r4_wr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_gnt_i && !mem_err_i) |=> (mem_req_o && mem_we_o));

  a_r9_err_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && mem_err_i) |=> (!mem_req_o && (|err_flags_i)));

  a_r11_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(done_flags_i | err_flags_i)));
endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i), .mem_err_i(mem_err_i),
  .irq_o(irq_o), .done_flags_i(done_q), .err_flags_i(err_q)
);

// File: tb/tb_dma_engine.sv
`timescale 1ns/1ps
module tb_dma_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [6:0]  hw_req = '0;
  logic        mem_req, mem_we, mem_gnt, mem_err, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        gnt_en = 1'b1, stall_mode = 1'b0;
  logic [31:0] mem [256];

  typedef struct { logic [31:0] a; logic [31:0] d; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dma_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .hw_req_i(hw_req),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .mem_err_i(mem_err), .irq_o(irq)
  );

  // memory model: errors above 2 GiB, optional every-other-cycle stall
  assign mem_gnt   = mem_req & gnt_en;
  assign mem_err   = mem_addr[31];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    gnt_en <= stall_mode ? ~gnt_en : 1'b1;
    if (mem_req && mem_we && mem_gnt && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
  end

  function automatic logic [31:0] pat(input logic [31:0] idx);
    return 32'h1000_0000 + idx * 32'h0001_0101;
  endfunction

  function automatic logic [31:0] mk(input bit en, go, si, di, input int bl, input bit hw,
                                     input int sel, input int pr);
    return 32'(en) | (32'(go) << 1) | (32'(si) << 2) | (32'(di) << 3) | (32'(bl) << 4)
         | (32'(sel) << 6) | (32'(hw) << 9) | (32'(pr) << 10);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic push_xfer(input logic [31:0] s, d, input int n, input bit si, di);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.a = d + (di ? 32'(4 * k) : 32'd0);
      it.d = pat(((s + (si ? 32'(4 * k) : 32'd0)) >> 2) & 32'hFF);
      exp_q.push_back(it);
    end
  endtask

  task automatic wait_flag(input int bitn, input string tag);
    logic [31:0] v;
    bit seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      rd_reg(4'd12, v);
      seen = v[bitn];
    end
    check(seen, tag, 32'(seen), 32'd1);
  endtask

  task automatic drained(input string tag);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic set_ch(input int c, input logic [31:0] s, d, n);
    wr_reg(4'(4 * c), s); wr_reg(4'(4 * c + 1), d); wr_reg(4'(4 * c + 2), n);
  endtask

  // scoreboard monitor: each granted write is popped and compared in order
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_gnt && !mem_err) begin
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected write", mem_addr, 32'd0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        check(mem_addr == it.a, "R5/R7 write address", mem_addr, it.a);
        check(mem_wdata == it.d, "R4 write data", mem_wdata, it.d);
      end
    end
  end

  task automatic run_all();
    logic [31:0] v;
    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    check(mem_req == 1'b0, "R1 req after reset", 32'(mem_req), 0);
    rd_reg(4'd12, v); check(v == 0, "R1 status reset", v, 0);
    rd_reg(4'd2, v);  check(v == 0, "R1 count reset", v, 0);

    // R2 R5 R6: software start, both increment, burst 4 over 5 words, stalling bus
    stall_mode = 1'b1;
    set_ch(0, 32'h100, 32'h200, 5);
    push_xfer(32'h100, 32'h200, 5, 1, 1);
    wr_reg(4'd3, mk(1, 1, 1, 1, 1, 0, 0, 0));
    rd_reg(4'd3, v); check(v[1] == 1'b1 || exp_q.size() == 0, "R2 busy bit", v, 32'h2);
    wait_flag(0, "R8 done ch0");
    drained("R4 ch0 drained");
    rd_reg(4'd0, v); check(v == 32'h114, "R5 src incremented", v, 32'h114);
    rd_reg(4'd1, v); check(v == 32'h214, "R5 dst incremented", v, 32'h214);
    rd_reg(4'd2, v); check(v == 0, "R8 count zero", v, 0);
    rd_reg(4'd3, v); check(v[0] == 1'b0, "R8 enable cleared", v, 0);
    wr_reg(4'd12, 32'h77);
    rd_reg(4'd12, v); check(v == 0, "R10 w1c clears", v, 0);

    // R5 fixed source, single bursts
    set_ch(1, 32'h40, 32'h240, 3);
    for (int k = 0; k < 3; k++) begin
      item_t it; it.a = 32'h240 + 32'(4 * k); it.d = pat(32'h10); exp_q.push_back(it);
    end
    wr_reg(4'd7, mk(1, 1, 0, 1, 0, 0, 0, 0));
    wait_flag(1, "R8 done ch1");
    drained("R5 fixed src drained");
    rd_reg(4'd4, v); check(v == 32'h40, "R5 src fixed", v, 32'h40);

    // R5 R6 fixed destination, burst 8 larger than count -> singles
    set_ch(2, 32'h60, 32'h280, 4);
    for (int k = 0; k < 4; k++) begin
      item_t it; it.a = 32'h280; it.d = pat(32'h18 + 32'(k)); exp_q.push_back(it);
    end
    wr_reg(4'd11, mk(1, 1, 1, 0, 2, 0, 0, 0));
    wait_flag(2, "R8 done ch2");
    drained("R6 singles drained");
    rd_reg(4'd9, v); check(v == 32'h280, "R5 dst fixed", v, 32'h280);
    wr_reg(4'd12, 32'h77);
    stall_mode = 1'b0;

    // R3 hardware trigger, wrong line ignored, picked line fires
    set_ch(1, 32'h80, 32'h2A0, 2);
    wr_reg(4'd7, mk(1, 0, 1, 1, 0, 1, 5, 0));
    hw_req = 7'b001_0000;
    repeat (10) @(negedge clk);
    rd_reg(4'd6, v); check(v == 2, "R3 other line ignored", v, 2);
    push_xfer(32'h80, 32'h2A0, 2, 1, 1);
    hw_req = 7'b010_0000;
    wait_flag(1, "R3 picked line fires");
    hw_req = '0;
    drained("R3 drained");

    // R3 select 7 picks nothing
    set_ch(2, 32'h0, 32'h2B0, 2);
    wr_reg(4'd11, mk(1, 0, 1, 1, 0, 1, 7, 0));
    hw_req = 7'h7F;
    repeat (20) @(negedge clk);
    rd_reg(4'd11, v); check(v[1] == 1'b0, "R3 sel7 not busy", v, 0);
    rd_reg(4'd10, v); check(v == 2, "R3 sel7 count kept", v, 2);
    wr_reg(4'd11, 32'h0);
    hw_req = '0;
    wr_reg(4'd12, 32'h77);

    // R7 higher priority first
    set_ch(0, 32'h0, 32'h2C0, 4);
    set_ch(1, 32'h20, 32'h2E0, 4);
    wr_reg(4'd3, mk(1, 0, 1, 1, 1, 1, 2, 1));
    wr_reg(4'd7, mk(1, 0, 1, 1, 1, 1, 2, 5));
    push_xfer(32'h20, 32'h2E0, 4, 1, 1);
    push_xfer(32'h0, 32'h2C0, 4, 1, 1);
    hw_req = 7'b000_0100;
    wait_flag(0, "R7 prio ch0 done");
    hw_req = '0;
    drained("R7 priority order");
    wr_reg(4'd12, 32'h77);

    // R7 tie -> lowest index
    set_ch(0, 32'h30, 32'h300, 2);
    set_ch(1, 32'h38, 32'h320, 2);
    wr_reg(4'd3, mk(1, 0, 1, 1, 1, 1, 3, 3));
    wr_reg(4'd7, mk(1, 0, 1, 1, 1, 1, 3, 3));
    push_xfer(32'h30, 32'h300, 2, 1, 1);
    push_xfer(32'h38, 32'h320, 2, 1, 1);
    hw_req = 7'b000_1000;
    wait_flag(1, "R7 tie ch1 done");
    hw_req = '0;
    drained("R7 tie order");
    wr_reg(4'd12, 32'h77);

    // R6 trailing singles allow a higher-priority channel to cut in
    set_ch(0, 32'h50, 32'h340, 3);
    set_ch(1, 32'h70, 32'h360, 4);
    wr_reg(4'd3, mk(1, 0, 1, 1, 2, 1, 0, 0));
    wr_reg(4'd7, mk(1, 0, 1, 1, 1, 1, 1, 7));
    push_xfer(32'h50, 32'h340, 1, 1, 1);
    push_xfer(32'h70, 32'h360, 4, 1, 1);
    push_xfer(32'h54, 32'h344, 2, 1, 1);
    hw_req = 7'b000_0001;
    do @(negedge clk); while (!(mem_req && mem_we));
    hw_req = 7'b000_0011;
    wait_flag(0, "R6 singles ch0 done");
    hw_req = '0;
    drained("R6 preempt between singles");
    wr_reg(4'd12, 32'h77);

    // R6 R7 a whole burst is not interrupted
    set_ch(0, 32'h50, 32'h3A0, 4);
    set_ch(1, 32'h70, 32'h3C0, 4);
    wr_reg(4'd3, mk(1, 0, 1, 1, 1, 1, 0, 0));
    wr_reg(4'd7, mk(1, 0, 1, 1, 1, 1, 1, 7));
    push_xfer(32'h50, 32'h3A0, 4, 1, 1);
    push_xfer(32'h70, 32'h3C0, 4, 1, 1);
    hw_req = 7'b000_0001;
    do @(negedge clk); while (!(mem_req && mem_we));
    hw_req = 7'b000_0011;
    wait_flag(1, "R6 burst ch1 done");
    hw_req = '0;
    drained("R6 burst kept whole");
    wr_reg(4'd12, 32'h77);

    // R8 zero count completes with no bus access
    set_ch(1, 32'h0, 32'h2F0, 0);
    wr_reg(4'd7, mk(1, 1, 1, 1, 0, 0, 0, 0));
    wait_flag(1, "R8 zero count done");
    drained("R8 zero count no writes");

    // R11 masked done drives irq only when unmasked
    check(irq == 1'b0, "R11 masked done", 32'(irq), 0);
    wr_reg(4'd13, 32'h2);
    #1; check(irq == 1'b1, "R11 unmasked done", 32'(irq), 1);
    wr_reg(4'd12, 32'h0);
    rd_reg(4'd12, v); check(v == 32'h2, "R10 write 0 keeps flag", v, 32'h2);
    wr_reg(4'd12, 32'h2);
    #1; check(irq == 1'b0, "R10 R11 cleared", 32'(irq), 0);
    wr_reg(4'd13, 32'h0);

    // R9 bus error on third word
    set_ch(2, 32'h7FFF_FFF8, 32'h380, 5);
    push_xfer(32'h7FFF_FFF8, 32'h380, 2, 1, 1);
    wr_reg(4'd11, mk(1, 1, 1, 1, 0, 0, 0, 0));
    wait_flag(6, "R9 error flag");
    drained("R9 words before error");
    rd_reg(4'd10, v); check(v == 3, "R9 count kept", v, 3);
    rd_reg(4'd8, v);  check(v == 32'h8000_0000, "R9 src at failing word", v, 32'h8000_0000);
    rd_reg(4'd11, v); check(v[0] == 1'b0, "R9 enable cleared", v, 0);
    rd_reg(4'd12, v); check(v == 32'h40, "R9 only error flag", v, 32'h40);
    check(irq == 1'b0, "R11 masked error", 32'(irq), 0);
    wr_reg(4'd13, 32'h4);
    #1; check(irq == 1'b1, "R11 unmasked error", 32'(irq), 1);
    wr_reg(4'd12, 32'h40);
    #1; check(irq == 1'b0, "R10 error w1c", 32'(irq), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(32'(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule